// File: doc/BRIEF.md
# Buffered ADC Trigger Compare Unit

This block keeps two ADC trigger compare values, channel A and channel B. Software cannot write either value directly. It writes a staging register for each channel, and the block copies both staging registers into the live compare registers when a chosen timer event occurs. A two-bit timing code selects that event. What each code means depends on the timer's operating mode. In the up/down (complementary PWM) mode the copy can follow the counter's crest, its trough, or both. In the other modes it follows a compare-match strobe. That strobe comes from the partner channel in reset-synchronized PWM mode, and from the local channel in PWM mode 1 and in normal mode.

Each live register is compared with the timer count. A match raises a one-cycle trigger pulse for the ADC, and each channel has its own enable. Both the staging and the live registers can be read back.

Top module: `adc_trig_cmp`

## Requirements
- R1: While reset is asserted and after it is released, both staging registers, both live registers and the timing code read zero, and both trigger outputs are low.
- R2: A staging write strobe loads the shared write data into that channel's staging register, visible on the next cycle. A live register changes only through a copy.
- R3: With timing code 00, no copy happens in any mode, whatever strobes arrive.
- R4: In mode 00 (complementary PWM), code 01 copies on the crest strobe, code 10 copies on the trough strobe, and code 11 copies on either. The compare-match strobes are ignored in this mode.
- R5: In mode 01 (reset-synchronized PWM), code 01 copies only on the partner-channel compare-match strobe.
- R6: In mode 10 (PWM mode 1) and mode 11 (normal), code 01 copies only on the local compare-match strobe.
- R7: A copy always moves both channels together, A and B, in the same cycle.
- R8: When the code has bit 1 set and the mode is not 00, the illegal flag is high and no copy happens.
- R9: A copy takes the staging value held before the clock edge. A staging write in the same cycle lands only in the staging register and waits for the next qualifying event.
- R10: A trigger output pulses high for exactly one cycle. The pulse comes in the cycle after the first cycle in which the count equals the live register with the enable high. A match that is held produces no further pulse.
- R11: Each trigger enable gates only its own channel. While the enable is low, that channel's trigger stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Timer mode: 00 complementary, 01 reset-sync, 10 PWM1, 11 normal |
| sel_we_i | input | 1 | Write strobe for the timing code |
| sel_wdata_i | input | 2 | New timing code |
| buf_a_we_i | input | 1 | Write strobe, staging A |
| buf_b_we_i | input | 1 | Write strobe, staging B |
| buf_wdata_i | input | W | Staging write data |
| cnt_i | input | W | Timer count |
| crest_i | input | 1 | Counter at crest |
| trough_i | input | 1 | Counter at trough |
| local_cm_i | input | 1 | Local channel compare match |
| partner_cm_i | input | 1 | Partner channel compare match |
| trig_en_a_i | input | 1 | Trigger enable A |
| trig_en_b_i | input | 1 | Trigger enable B |
| sel_o | output | 2 | Current timing code |
| illegal_o | output | 1 | Prohibited code for current mode |
| buf_a_o | output | W | Staging register A |
| buf_b_o | output | W | Staging register B |
| act_a_o | output | W | Live compare register A |
| act_b_o | output | W | Live compare register B |
| trig_a_o | output | 1 | ADC trigger pulse A |
| trig_b_o | output | 1 | ADC trigger pulse B |

## Verification
The assertions assume that mode_i is sampled on the same edge as the event strobes, so a mode change lands on a clean cycle boundary. They also assume the strobes are plain single-cycle levels that are sampled only at the edge. The stimulus drives every input just after the falling edge and holds it for a full cycle. It draws counts and write data from a narrow range so that matches and copies occur often. It changes the mode freely, including into the prohibited codes, so that the flag and the suppressed copies are exercised.

// File: rtl/adtrig_pkg.sv
package adtrig_pkg;
  typedef enum logic [1:0] {
    MODE_CPWM   = 2'b00,
    MODE_RSPWM  = 2'b01,
    MODE_PWM1   = 2'b10,
    MODE_NORMAL = 2'b11
  } tmode_e;

  localparam logic [1:0] SEL_OFF  = 2'b00;
  localparam logic [1:0] SEL_CM   = 2'b01;
  localparam logic [1:0] SEL_TRGH = 2'b10;
  localparam logic [1:0] SEL_BOTH = 2'b11;
endpackage

// File: rtl/adtrig_sel_reg.sv
module adtrig_sel_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic [1:0] wdata_i,
  output logic [1:0] sel_o
);
  logic [1:0] sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (we_i) sel_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 2'b00;
    else        sel_q <= sel_d;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/adtrig_xfer_dec.sv
module adtrig_xfer_dec
  import adtrig_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] sel_i,
  input  logic       crest_i,
  input  logic       trough_i,
  input  logic       local_cm_i,
  input  logic       partner_cm_i,
  output logic       xfer_o,
  output logic       illegal_o
);
  tmode_e mode;
  assign mode = tmode_e'(mode_i);

  always_comb begin
    xfer_o    = 1'b0;
    illegal_o = 1'b0;
    unique case (mode)
      MODE_CPWM: begin
        unique case (sel_i)
          SEL_OFF:  xfer_o = 1'b0;
          SEL_CM:   xfer_o = crest_i;
          SEL_TRGH: xfer_o = trough_i;
          SEL_BOTH: xfer_o = crest_i | trough_i;
          default:  xfer_o = 1'b0;
        endcase
      end
      MODE_RSPWM: begin
        illegal_o = sel_i[1];
        xfer_o    = (sel_i == SEL_CM) & partner_cm_i;
      end
      MODE_PWM1, MODE_NORMAL: begin
        illegal_o = sel_i[1];
        xfer_o    = (sel_i == SEL_CM) & local_cm_i;
      end
      default: begin
        xfer_o    = 1'b0;
        illegal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/adtrig_chan.sv
module adtrig_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         xfer_i,
  input  logic [W-1:0] cnt_i,
  input  logic         en_i,
  output logic [W-1:0] buf_o,
  output logic [W-1:0] act_o,
  output logic         trig_o
);
  logic [W-1:0] buf_q, buf_d, act_q, act_d;
  logic         hit, hit_q, trig_q, trig_d;

  always_comb begin
    buf_d = buf_q;
    if (we_i) buf_d = wdata_i;
    act_d = act_q;
    if (xfer_i) act_d = buf_q;
    hit    = en_i && (cnt_i == act_q);
    trig_d = hit && !hit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      act_q  <= '0;
      hit_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      act_q  <= act_d;
      hit_q  <= hit;
      trig_q <= trig_d;
    end
  end

  assign buf_o  = buf_q;
  assign act_o  = act_q;
  assign trig_o = trig_q;
endmodule

// File: rtl/adc_trig_cmp.sv
module adc_trig_cmp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_i,
  input  logic         sel_we_i,
  input  logic [1:0]   sel_wdata_i,
  input  logic         buf_a_we_i,
  input  logic         buf_b_we_i,
  input  logic [W-1:0] buf_wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic         crest_i,
  input  logic         trough_i,
  input  logic         local_cm_i,
  input  logic         partner_cm_i,
  input  logic         trig_en_a_i,
  input  logic         trig_en_b_i,
  output logic [1:0]   sel_o,
  output logic         illegal_o,
  output logic [W-1:0] buf_a_o,
  output logic [W-1:0] buf_b_o,
  output logic [W-1:0] act_a_o,
  output logic [W-1:0] act_b_o,
  output logic         trig_a_o,
  output logic         trig_b_o
);
  localparam int NCH = 2;

  logic           xfer;
  logic [NCH-1:0] we_v, en_v, trig_v;
  logic [W-1:0]   buf_v [NCH];
  logic [W-1:0]   act_v [NCH];

  adtrig_sel_reg u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (sel_we_i),
    .wdata_i (sel_wdata_i),
    .sel_o   (sel_o)
  );

  adtrig_xfer_dec u_dec (
    .mode_i       (mode_i),
    .sel_i        (sel_o),
    .crest_i      (crest_i),
    .trough_i     (trough_i),
    .local_cm_i   (local_cm_i),
    .partner_cm_i (partner_cm_i),
    .xfer_o       (xfer),
    .illegal_o    (illegal_o)
  );

  assign we_v = {buf_b_we_i, buf_a_we_i};
  assign en_v = {trig_en_b_i, trig_en_a_i};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    adtrig_chan #(.W(W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we_v[i]),
      .wdata_i (buf_wdata_i),
      .xfer_i  (xfer),
      .cnt_i   (cnt_i),
      .en_i    (en_v[i]),
      .buf_o   (buf_v[i]),
      .act_o   (act_v[i]),
      .trig_o  (trig_v[i])
    );
  end

  assign buf_a_o  = buf_v[0];
  assign buf_b_o  = buf_v[1];
  assign act_a_o  = act_v[0];
  assign act_b_o  = act_v[1];
  assign trig_a_o = trig_v[0];
  assign trig_b_o = trig_v[1];
endmodule

// File: rtl/adtrig_chk.sv
module adtrig_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode_i,
  input logic         crest_i,
  input logic         partner_cm_i,
  input logic         trig_en_a_i,
  input logic         trig_en_b_i,
  input logic [1:0]   sel_o,
  input logic         illegal_o,
  input logic [W-1:0] buf_a_o,
  input logic [W-1:0] buf_b_o,
  input logic [W-1:0] act_a_o,
  input logic [W-1:0] act_b_o,
  input logic         trig_a_o,
  input logic         trig_b_o
);
  AST_SEL_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == 2'b00) |=> ($stable(act_a_o) && $stable(act_b_o))); // R3

  AST_CREST_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && sel_o == 2'b01 && crest_i)
      |=> (act_a_o == $past(buf_a_o) && act_b_o == $past(buf_b_o))); // R4

  AST_PARTNER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && sel_o == 2'b01 && partner_cm_i)
      |=> (act_a_o == $past(buf_a_o) && act_b_o == $past(buf_b_o))); // R5

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> ($stable(act_a_o) && $stable(act_b_o))); // R8

  AST_TRIG_A_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_a_o |=> !trig_a_o); // R10

  AST_TRIG_B_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_b_o |=> !trig_b_o); // R10

  AST_TRIG_A_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en_a_i |=> !trig_a_o); // R11

  AST_TRIG_B_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_en_b_i |=> !trig_b_o); // R11
endmodule

bind adc_trig_cmp adtrig_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .crest_i      (crest_i),
  .partner_cm_i (partner_cm_i),
  .trig_en_a_i  (trig_en_a_i),
  .trig_en_b_i  (trig_en_b_i),
  .sel_o        (sel_o),
  .illegal_o    (illegal_o),
  .buf_a_o      (buf_a_o),
  .buf_b_o      (buf_b_o),
  .act_a_o      (act_a_o),
  .act_b_o      (act_b_o),
  .trig_a_o     (trig_a_o),
  .trig_b_o     (trig_b_o)
);

// File: tb/adc_trig_cmp_bench.sv
module adc_trig_cmp_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_i = '0;
  logic sel_we_i = 1'b0;
  logic [1:0] sel_wdata_i = '0;
  logic buf_a_we_i = 1'b0, buf_b_we_i = 1'b0;
  logic [W-1:0] buf_wdata_i = '0, cnt_i = '1;
  logic crest_i = 1'b0, trough_i = 1'b0, local_cm_i = 1'b0, partner_cm_i = 1'b0;
  logic trig_en_a_i = 1'b0, trig_en_b_i = 1'b0;
  logic [1:0] sel_o;
  logic illegal_o, trig_a_o, trig_b_o;
  logic [W-1:0] buf_a_o, buf_b_o, act_a_o, act_b_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] m_buf_a = '0, m_buf_b = '0, m_act_a = '0, m_act_b = '0;
  logic [1:0]   m_sel = '0;
  logic         m_hit_a = 1'b0, m_hit_b = 1'b0, m_trig_a = 1'b0, m_trig_b = 1'b0;

  always #2 clk = ~clk;

  adc_trig_cmp #(.W(W)) u_adc_trig_cmp (.*);

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_illegal(input logic [1:0] mode, input logic [1:0] sel);
    return (mode != 2'b00) && sel[1];
  endfunction

  function automatic logic exp_xfer(input logic [1:0] mode, input logic [1:0] sel);
    if (sel == 2'b00) return 1'b0;
    if (mode == 2'b00)
      return (sel[0] && crest_i) || (sel[1] && trough_i);
    if (sel != 2'b01) return 1'b0;
    if (mode == 2'b01) return partner_cm_i;
    return local_cm_i;
  endfunction

  function automatic string copy_tag(input logic [1:0] mode, input logic [1:0] sel);
    if (sel == 2'b00) return "R3";
    if (exp_illegal(mode, sel)) return "R8";
    if (mode == 2'b00) return "R4";
    if (mode == 2'b01) return "R5";
    return "R6";
  endfunction

  string tag;

  task automatic model_edge();
    logic ha, hb, x;
    tag = copy_tag(mode_i, m_sel);
    x  = exp_xfer(mode_i, m_sel);
    ha = trig_en_a_i && (cnt_i == m_act_a);
    hb = trig_en_b_i && (cnt_i == m_act_b);
    m_trig_a = ha && !m_hit_a;
    m_trig_b = hb && !m_hit_b;
    m_hit_a = ha;
    m_hit_b = hb;
    if (x) begin
      m_act_a = m_buf_a;
      m_act_b = m_buf_b;
    end
    if (buf_a_we_i) m_buf_a = buf_wdata_i;
    if (buf_b_we_i) m_buf_b = buf_wdata_i;
    if (sel_we_i) m_sel = sel_wdata_i;
  endtask

  task automatic compare_all();
    check("R2", "buf_a", buf_a_o, m_buf_a);
    check("R2", "buf_b", buf_b_o, m_buf_b);
    check(tag, "act_a", act_a_o, m_act_a);
    check("R7", "act_b", act_b_o, m_act_b);
    check("R2", "sel", sel_o, m_sel);
    check("R8", "illegal", illegal_o, exp_illegal(mode_i, m_sel));
    check("R10", "trig_a", trig_a_o, m_trig_a);
    check("R11", "trig_b", trig_b_o, m_trig_b);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    sel_we_i = 0; buf_a_we_i = 0; buf_b_we_i = 0;
    crest_i = 0; trough_i = 0; local_cm_i = 0; partner_cm_i = 0;
  endtask

  task automatic wr_buf(input bit a, input bit b, input logic [W-1:0] d);
    buf_a_we_i = a; buf_b_we_i = b; buf_wdata_i = d;
  endtask

  task automatic wr_sel(input logic [1:0] s);
    sel_we_i = 1'b1; sel_wdata_i = s;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: state under reset
    check("R1", "act_a rst", act_a_o, 0);
    check("R1", "buf_b rst", buf_b_o, 0);
    check("R1", "sel rst", sel_o, 0);
    check("R1", "trig_a rst", trig_a_o, 0);
    rst_n = 1'b1;
    cycle();
    check("R1", "act_b after", act_b_o, 0);

    // R3: code 00 ignores every strobe
    mode_i = 2'b00; wr_buf(1, 1, 16'h0005); cycle();
    wr_buf(0, 1, 16'h0009); cycle();
    crest_i = 1; trough_i = 1; local_cm_i = 1; partner_cm_i = 1; cycle();
    check("R3", "act_a held", act_a_o, 0);

    // R4: crest copy with code 01, trough ignored
    wr_sel(2'b01); cycle();
    trough_i = 1; local_cm_i = 1; cycle();
    check("R4", "trough ignored", act_a_o, 0);
    crest_i = 1; cycle();
    check("R4", "crest copy A", act_a_o, 16'h0005);
    check("R7", "crest copy B", act_b_o, 16'h0009);

    // R9: same-cycle write and copy
    wr_buf(1, 0, 16'h0003); cycle();
    wr_buf(1, 0, 16'h0007); crest_i = 1; cycle();
    check("R9", "act takes old", act_a_o, 16'h0003);
    check("R9", "buf takes new", buf_a_o, 16'h0007);

    // R4: code 10 uses trough only
    wr_sel(2'b10); cycle();
    crest_i = 1; cycle();
    check("R4", "crest ignored", act_a_o, 16'h0003);
    trough_i = 1; cycle();
    check("R4", "trough copy", act_a_o, 16'h0007);

    // R5: reset-sync mode, partner strobe only
    mode_i = 2'b01; wr_sel(2'b01); wr_buf(1, 0, 16'h0011); cycle();
    local_cm_i = 1; crest_i = 1; cycle();
    check("R5", "local ignored", act_a_o, 16'h0007);
    partner_cm_i = 1; cycle();
    check("R5", "partner copy", act_a_o, 16'h0011);

    // R6: normal mode, local strobe only
    mode_i = 2'b11; wr_buf(1, 0, 16'h0022); cycle();
    partner_cm_i = 1; cycle();
    check("R6", "partner ignored", act_a_o, 16'h0011);
    local_cm_i = 1; cycle();
    check("R6", "local copy", act_a_o, 16'h0022);

    // R8: prohibited code outside complementary mode
    wr_sel(2'b11); wr_buf(1, 0, 16'h0033); cycle();
    check("R8", "illegal flag", illegal_o, 1);
    crest_i = 1; trough_i = 1; local_cm_i = 1; partner_cm_i = 1; cycle();
    check("R8", "no copy", act_a_o, 16'h0022);

    // R10 / R11: held match gives one pulse, B disabled
    mode_i = 2'b00; wr_sel(2'b00); cycle();
    cnt_i = 16'h0022; trig_en_a_i = 1; trig_en_b_i = 0; cycle();
    check("R10", "pulse", trig_a_o, 1);
    cycle();
    check("R10", "held no repeat", trig_a_o, 0);
    check("R11", "B gated", trig_b_o, 0);
    cycle();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      mode_i = 2'($urandom);
      if (($urandom % 8) == 0) wr_sel(2'($urandom));
      buf_a_we_i = ($urandom % 4) == 0;
      buf_b_we_i = ($urandom % 4) == 0;
      buf_wdata_i = W'($urandom % 4);
      cnt_i = W'($urandom % 4);
      crest_i = ($urandom % 4) == 0;
      trough_i = ($urandom % 4) == 0;
      local_cm_i = ($urandom % 4) == 0;
      partner_cm_i = ($urandom % 4) == 0;
      trig_en_a_i = ($urandom % 3) != 0;
      trig_en_b_i = ($urandom % 3) != 0;
      cycle();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule